// File: doc/BRIEF.md
# Keyboard Input Port

This block is a single-character keyboard receiver that sits on a 16-bit memory-mapped bus. A key source gives it an 8-bit character together with a one-cycle strobe. The port latches that character, raises a ready flag and refuses any further strobes until software has collected the character. Software sees two bus locations. The control/status word at 0xFE00 holds the ready flag and an interrupt-enable bit. The character word at 0xFE02 holds the character in its low byte.

A two-state machine controls capture. In PORT_EMPTY the port waits for a key. The CAPTURE transition (a strobe while empty) latches the character and moves to PORT_FULL. In PORT_FULL the port ignores strobes. The CONSUME transition (a bus read of the character word) returns to PORT_EMPTY. An interrupt request is presented to the processor whenever the port is full and software has set the enable bit. A bus read returns its value combinationally in the same cycle as the read strobe. Any side effect of the read takes effect at the following clock edge.

Top module: `kbd_input_port`

## Requirements
- R1: After reset the status word (0xFE00) reads 0x0000, the character word (0xFE02) reads 0x0000 and irq is 0.
- R2: A key strobe while the port is empty is captured at the next clock edge. From then on, 0xFE02 reads the character in bits [7:0] with bits [15:8] zero, and status bit 15 (ready) reads 1.
- R3: While ready is 1, key strobes are ignored and the held character is not replaced.
- R4: A read of 0xFE02 clears ready at the following edge, after which the next key strobe is captured again.
- R5: A bus write to 0xFE00 changes only bit 14 (interrupt enable). The ready bit cannot be written, and status bits 13..0 always read 0.
- R6: irq is 1 exactly when ready and interrupt enable are both 1.
- R7: When a key strobe and a read of 0xFE02 arrive in the same cycle while the port is full, the read wins. The read returns the old character, ready is cleared, and the new character is discarded.
- R8: Reads of 0xFE00 have no side effect on ready. Reads of unmapped addresses return 0x0000.
- R9: Bus writes to 0xFE02 have no effect on the held character or on ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | One-cycle strobe from the key source |
| key_char | input | 8 | Character code presented with key_valid |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 16 | Bus write data |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_rdata | output | 16 | Bus read data, valid in the cycle of bus_rd |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach is the collision in which a new key strobe and the consuming read of the character word fall in the same clock cycle while a character is already held. The stimulus sets up this case by first filling the port. It then drives the strobe and the read together on one falling edge. Afterwards it reads the character word again without any strobe, to prove that the colliding character was dropped. The same sweep repeats capture, blocking and consumption for every one of the 256 character codes with the enable bit alternating, so that irq is compared in both enable states.

// File: rtl/kbd_pkg.sv
package kbd_pkg;

    // Capture state of the port
    typedef enum logic {
        PORT_EMPTY = 1'b0,
        PORT_FULL  = 1'b1
    } port_state_t;

    // Decoded bus accesses
    typedef struct packed {
        logic stat_rd;
        logic stat_wr;
        logic data_rd;
        logic data_wr;
    } bus_hit_t;

endpackage

// File: rtl/kbd_bus_decode.sv
module kbd_bus_decode #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] STAT_ADDR = 16'hFE00,
    parameter logic [15:0] DATA_ADDR = 16'hFE02
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output kbd_pkg::bus_hit_t hit
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);

    logic stat_sel;
    logic data_sel;

    always_comb begin
        stat_sel    = (addr == STAT_A);
        data_sel    = (addr == DATA_A);
        hit.stat_rd = stat_sel & rd;
        hit.stat_wr = stat_sel & wr;
        hit.data_rd = data_sel & rd;
        hit.data_wr = data_sel & wr;
    end
endmodule

// File: rtl/kbd_capture_fsm.sv
module kbd_capture_fsm #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_char,
    input  logic              consume,
    output logic              full,
    output logic [CHAR_W-1:0] held_char
);
    import kbd_pkg::*;

    port_state_t state_q, state_d;
    logic        capture;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PORT_EMPTY;
        else        state_q <= state_d;
    end

    // transitions: CAPTURE (empty + strobe), CONSUME (full + data read)
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            PORT_EMPTY: begin
                if (key_valid) begin
                    state_d = PORT_FULL;
                    capture = 1'b1;
                end
            end
            PORT_FULL: begin
                if (consume) state_d = PORT_EMPTY;
            end
        endcase
    end

    // character holding register
    always_ff @(posedge clk) begin
        if (!rst_n)       held_char <= '0;
        else if (capture) held_char <= key_char;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            PORT_EMPTY: full = 1'b0;
            PORT_FULL:  full = 1'b1;
        endcase
    end
endmodule

// File: rtl/kbd_status_reg.sv
module kbd_status_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic ie_wbit,
    output logic ie
);
    always_ff @(posedge clk) begin
        if (!rst_n)     ie <= 1'b0;
        else if (wr_en) ie <= ie_wbit;
    end
endmodule

// File: rtl/kbd_input_port.sv
module kbd_input_port #(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 16,
    parameter int          CHAR_W    = 8,
    parameter logic [15:0] STAT_ADDR = 16'hFE00,
    parameter logic [15:0] DATA_ADDR = 16'hFE02,
    parameter int          RDY_BIT   = 15,
    parameter int          IE_BIT    = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [CHAR_W-1:0] key_char,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    import kbd_pkg::*;

    bus_hit_t          hit;
    logic              full;
    logic              ie_q;
    logic [CHAR_W-1:0] held_char;
    logic [DATA_W-1:0] stat_word;
    logic [DATA_W-1:0] data_word;
    logic              data_rd;
    logic              stat_wr;
    logic              unused_inputs;

    kbd_bus_decode #(
        .ADDR_W   (ADDR_W),
        .STAT_ADDR(STAT_ADDR),
        .DATA_ADDR(DATA_ADDR)
    ) u_dec (
        .addr(bus_addr),
        .rd  (bus_rd),
        .wr  (bus_wr),
        .hit (hit)
    );

    assign data_rd = hit.data_rd;
    assign stat_wr = hit.stat_wr;
    // the character word is read-only; its write strobe and other wdata bits are not used
    assign unused_inputs = hit.data_wr ^ (^bus_wdata);

    kbd_capture_fsm #(.CHAR_W(CHAR_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_valid(key_valid),
        .key_char (key_char),
        .consume  (data_rd),
        .full     (full),
        .held_char(held_char)
    );

    kbd_status_reg u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (stat_wr),
        .ie_wbit(bus_wdata[IE_BIT]),
        .ie     (ie_q)
    );

    // assemble register images
    always_comb begin
        stat_word = '0;
        data_word = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i == RDY_BIT) stat_word[i] = full;
            if (i == IE_BIT)  stat_word[i] = ie_q;
            if (i < CHAR_W)   data_word[i] = held_char[i];
        end
    end

    // read mux and interrupt
    always_comb begin
        if (hit.stat_rd)      bus_rdata = stat_word;
        else if (hit.data_rd) bus_rdata = data_word;
        else                  bus_rdata = '0;
        irq = full & ie_q;
    end
endmodule

// File: rtl/kbd_input_port_chk.sv
module kbd_input_port_chk #(
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              key_valid,
    input logic              full,
    input logic              ie,
    input logic [CHAR_W-1:0] held,
    input logic              data_rd,
    input logic              stat_wr,
    input logic              irq
);
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!full && key_valid) |=> full);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !data_rd) |=> (full && $stable(held)));

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && data_rd) |=> !full);

    p_ie_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> $stable(ie));

    p_irq_needs_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (full && ie));

    p_irq_raised_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && ie) |-> irq);

    p_read_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && key_valid && data_rd) |=> (!full && $stable(held)));
endmodule

bind kbd_input_port kbd_input_port_chk #(.CHAR_W(CHAR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_valid(key_valid),
    .full     (full),
    .ie       (ie_q),
    .held     (held_char),
    .data_rd  (data_rd),
    .stat_wr  (stat_wr),
    .irq      (irq)
);

// File: tb/kbd_input_port_test.sv
module kbd_input_port_test;
    localparam logic [15:0] A_STAT = 16'hFE00;
    localparam logic [15:0] A_DATA = 16'hFE02;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_valid = 1'b0;
    logic [7:0]  key_char = '0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] last_char = 8'h00;

    kbd_input_port uut (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_char(key_char),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #10 clk = ~clk;  // 50 MHz

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic [7:0] c);
        @(negedge clk); key_valid = 1'b1; key_char = c;
        @(negedge clk); key_valid = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] v);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #2 v = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #2 check("R1 irq", {15'd0, irq}, 16'd0);
        rd(A_STAT, v); check("R1 status", v, 16'h0000);
        rd(A_DATA, v); check("R1 data", v, 16'h0000);

        // R5 status write: only bit 14 sticks
        wr(A_STAT, 16'hFFFF);
        rd(A_STAT, v); check("R5 write ones", v, 16'h4000);
        #2 check("R6 irq empty", {15'd0, irq}, 16'd0);
        wr(A_STAT, 16'h0000);
        rd(A_STAT, v); check("R5 write zero", v, 16'h0000);

        // Sweep of all character codes, enable alternating (R2 R3 R4 R6)
        for (int c = 0; c < 256; c++) begin
            logic ie_b;
            ie_b = c[0];
            wr(A_STAT, {1'b0, ie_b, 14'd0});
            strobe(8'(c));
            rd(A_STAT, v); check("R2 ready set", v, {1'b1, ie_b, 14'd0});
            #2 check("R6 irq full", {15'd0, irq}, {15'd0, ie_b});
            strobe(8'(c) ^ 8'h5A);
            rd(A_DATA, v); check("R3 held char", v, {8'h00, 8'(c)});
            rd(A_STAT, v); check("R4 ready cleared", v, {1'b0, ie_b, 14'd0});
            #2 check("R6 irq cleared", {15'd0, irq}, 16'd0);
            last_char = 8'(c);
        end

        // R5 ready bit not writable while full
        wr(A_STAT, 16'h0000);
        strobe(8'h41);
        wr(A_STAT, 16'h0000);
        rd(A_STAT, v); check("R5 ready kept", v, 16'h8000);
        // R8 status reads have no side effect; unmapped reads zero
        rd(A_STAT, v); check("R8 status re-read", v, 16'h8000);
        rd(16'hFE01, v); check("R8 unmapped FE01", v, 16'h0000);
        rd(16'hFE04, v); check("R8 unmapped FE04", v, 16'h0000);
        // R9 data writes ignored
        wr(A_DATA, 16'h1234);
        rd(A_STAT, v); check("R9 ready after data write", v, 16'h8000);
        rd(A_DATA, v); check("R9 data after write", v, 16'h0041);
        wr(A_DATA, 16'h00FF);
        rd(A_STAT, v); check("R9 empty after data write", v, 16'h0000);
        rd(A_DATA, v); check("R9 data held", v, 16'h0041);

        // R4 capture again after consume
        strobe(8'h7E);
        rd(A_DATA, v); check("R4 recapture", v, 16'h007E);

        // R7 collision: read wins, strobe dropped
        strobe(8'h30);
        @(negedge clk);
        key_valid = 1'b1; key_char = 8'h31; bus_addr = A_DATA; bus_rd = 1'b1;
        #2 v = bus_rdata;
        check("R7 collision read", v, 16'h0030);
        @(negedge clk);
        key_valid = 1'b0; bus_rd = 1'b0;
        rd(A_STAT, v); check("R7 ready cleared", v, 16'h0000);
        rd(A_DATA, v); check("R7 strobe dropped", v, 16'h0030);
        strobe(8'h32);
        rd(A_DATA, v); check("R7 next capture", v, 16'h0032);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule